// File: doc/BRIEF.md
# Logic-Cell Storage Bank

This block is the register stage that sits behind the lookup tables of one programmable logic cell. It holds four storage bits. Static configuration inputs set each bit up on its own. A bit can be an edge-triggered flip-flop or a level-sensitive latch. It can load a value of 1 or 0 when set/reset fires. It takes its data from one of several sources: the lookup-table output, a direct bypass input, a pad on a horizontal neighbour, a pad on a vertical neighbour, or a constant zero.

All four bits share one clock/gate line, one clock enable, one local set/reset line and one active-low global set/reset. The local line has a cell-wide mode. In synchronous mode it forces the bits on a clock edge. In asynchronous mode it forces them at once. In data-select mode it is no reset at all: it chooses between the lookup-table output and the direct input. A priority option lets a synchronous local reset win over a low clock enable.

The configuration inputs are assumed to be static and are changed only while global set/reset is asserted.

Top module: `lcell_store_bank`

## Requirements
- R1: While `gsrN` is low, every bit of `q` equals its `cfgSetVal` bit at once, with no clock edge needed, whatever the mode and the other inputs.
- R2: A flip-flop bit (`cfgLatch` bit = 0) with `ceEn` high and no local force loads its selected data on the rising edge of `clk`, and only on that edge.
- R3: A flip-flop bit with `ceEn` low keeps its value across a rising edge when no local force applies.
- R4: The 3-bit field `cfgSrcSel[3*i+2:3*i]` selects the data of bit i as follows: 1 = `lutOut[i]`, 2 = `directIn[i]`, 3 = `padHoriz[i]`, 4 = `padVert[i]`. The codes 0, 5, 6 and 7 select constant 0.
- R5: In synchronous mode (`cfgLsrMode` = 0 or 3), `lsrIn` high together with `ceEn` high drives each flip-flop bit to `cfgSetVal` on the next rising edge, and not before that edge.
- R6: In synchronous mode with `ceEn` low and `lsrIn` high, a flip-flop bit holds its value when `cfgLsrPrio` = 0 and is forced to `cfgSetVal` on the edge when `cfgLsrPrio` = 1.
- R7: In asynchronous mode (`cfgLsrMode` = 1), `lsrIn` high drives every bit to `cfgSetVal` at once, without a clock edge.
- R8: In data-select mode (`cfgLsrMode` = 2), `lsrIn` never forces a bit. `lsrIn` = 0 selects `lutOut[i]` and `lsrIn` = 1 selects `directIn[i]`, and `cfgSrcSel` has no effect.
- R9: A latch bit (`cfgLatch` bit = 1) follows its selected data while `clk` is high and holds while `clk` is low. `ceEn` has no effect on it.
- R10: In synchronous mode, a latch bit with `lsrIn` high takes `cfgSetVal` while `clk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for flip-flop bits, gate for latch bits |
| gsrN | input | 1 | Global set/reset, active low, asynchronous |
| ceEn | input | 1 | Clock enable, applies to flip-flop bits only |
| lsrIn | input | 1 | Local set/reset, or data selector in data-select mode |
| lutOut | input | NUM_BITS | Lookup-table output, one bit per storage bit |
| directIn | input | NUM_BITS | Direct data bypassing the lookup table |
| padHoriz | input | NUM_BITS | Input from the nearest pad to the left or right |
| padVert | input | NUM_BITS | Input from the nearest pad above or below |
| cfgLatch | input | NUM_BITS | Per bit: 1 = latch, 0 = flip-flop |
| cfgSetVal | input | NUM_BITS | Per bit: value loaded by global or local set/reset |
| cfgLsrMode | input | 2 | 0/3 = synchronous, 1 = asynchronous, 2 = data-select |
| cfgLsrPrio | input | 1 | 1 = synchronous local set/reset ignores clock enable |
| cfgSrcSel | input | 3*NUM_BITS | Per-bit data source code |
| q | output | NUM_BITS | Storage bit outputs |

## Verification
Data patterns use a different one-hot value on each source, so a wrong source-select mapping shows up as a wrong bit position. A second pass uses only the zero codes with all sources high, which catches any unused code that leaks data. The local line is driven with the enable both high and low under each priority setting, which separates enable gating from priority override. It is also driven half a period before an edge, which separates asynchronous from synchronous forcing. Latch tests change the data in both phases of the gate to show that the bit is transparent while the gate is high and holds while it is low.

// File: rtl/lcell_store_pkg.sv
package lcell_store_pkg;

  localparam int SRC_W = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_ZERO   = 3'd0,
    SRC_LUT    = 3'd1,
    SRC_DIRECT = 3'd2,
    SRC_PADH   = 3'd3,
    SRC_PADV   = 3'd4
  } srcSel_e;

  typedef enum logic [1:0] {
    LSR_SYNC   = 2'd0,
    LSR_ASYNC  = 2'd1,
    LSR_SELECT = 2'd2,
    LSR_SYNC2  = 2'd3
  } lsrMode_e;

  // Strobes from control to datapath, shared by all bits of the cell
  typedef struct packed {
    logic clrNow;     // asynchronous force to set/reset value
    logic ffForce;    // synchronous force on the next edge (flip-flops)
    logic latForce;   // force while the gate is open (latches)
    logic ffLoad;     // flip-flops take new data on the edge
    logic pickDirect; // data-select mode chooses direct input
    logic frontMode;  // data-select mode active
  } cellStrobes_t;

endpackage

// File: rtl/lcell_store_ctrl.sv
module lcell_store_ctrl
  import lcell_store_pkg::*;
(
  input  logic         gsrN,
  input  logic         ceEn,
  input  logic         lsrIn,
  input  logic [1:0]   cfgLsrMode,
  input  logic         cfgLsrPrio,
  output cellStrobes_t strobes
);

  logic isAsync;
  logic isSelect;
  logic isSync;

  always_comb begin
    isAsync  = (cfgLsrMode == LSR_ASYNC);
    isSelect = (cfgLsrMode == LSR_SELECT);
    isSync   = !isAsync && !isSelect;

    strobes.clrNow     = !gsrN || (isAsync && lsrIn);
    strobes.ffForce    = isSync && lsrIn && (ceEn || cfgLsrPrio);
    strobes.latForce   = isSync && lsrIn;
    strobes.ffLoad     = ceEn;
    strobes.frontMode  = isSelect;
    strobes.pickDirect = isSelect && lsrIn;
  end

endmodule

// File: rtl/lcell_store_dp.sv
module lcell_store_dp
  import lcell_store_pkg::*;
#(
  parameter int NUM_BITS = 4
) (
  input  logic                  clk,
  input  cellStrobes_t          strobes,
  input  logic [NUM_BITS-1:0]   lutOut,
  input  logic [NUM_BITS-1:0]   directIn,
  input  logic [NUM_BITS-1:0]   padHoriz,
  input  logic [NUM_BITS-1:0]   padVert,
  input  logic [NUM_BITS-1:0]   cfgLatch,
  input  logic [NUM_BITS-1:0]   cfgSetVal,
  input  logic [SRC_W*NUM_BITS-1:0] cfgSrcSel,
  output logic [NUM_BITS-1:0]   q
);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    logic [SRC_W-1:0] srcCode;
    logic             srcData;
    logic             dataIn;
    logic             ffNext;
    logic             ffQ;
    logic             latQ;

    assign srcCode = cfgSrcSel[SRC_W*i +: SRC_W];

    always_comb begin
      case (srcCode)
        SRC_LUT:    srcData = lutOut[i];
        SRC_DIRECT: srcData = directIn[i];
        SRC_PADH:   srcData = padHoriz[i];
        SRC_PADV:   srcData = padVert[i];
        default:    srcData = 1'b0;
      endcase
    end

    always_comb begin
      if (strobes.frontMode)
        dataIn = strobes.pickDirect ? directIn[i] : lutOut[i];
      else
        dataIn = srcData;
    end

    // Enable as feedback mux ahead of the flip-flop
    always_comb begin
      if (strobes.ffForce)     ffNext = cfgSetVal[i];
      else if (strobes.ffLoad) ffNext = dataIn;
      else                     ffNext = ffQ;
    end

    always_ff @(posedge clk or posedge strobes.clrNow) begin
      if (strobes.clrNow) ffQ <= cfgSetVal[i];
      else                ffQ <= ffNext;
    end

    always_latch begin
      if (strobes.clrNow)
        latQ = cfgSetVal[i];
      else if (clk)
        latQ = strobes.latForce ? cfgSetVal[i] : dataIn;
    end

    assign q[i] = cfgLatch[i] ? latQ : ffQ;
  end

endmodule

// File: rtl/lcell_store_bank.sv
module lcell_store_bank
  import lcell_store_pkg::*;
#(
  parameter int NUM_BITS = 4
) (
  input  logic                      clk,
  input  logic                      gsrN,
  input  logic                      ceEn,
  input  logic                      lsrIn,
  input  logic [NUM_BITS-1:0]       lutOut,
  input  logic [NUM_BITS-1:0]       directIn,
  input  logic [NUM_BITS-1:0]       padHoriz,
  input  logic [NUM_BITS-1:0]       padVert,
  input  logic [NUM_BITS-1:0]       cfgLatch,
  input  logic [NUM_BITS-1:0]       cfgSetVal,
  input  logic [1:0]                cfgLsrMode,
  input  logic                      cfgLsrPrio,
  input  logic [SRC_W*NUM_BITS-1:0] cfgSrcSel,
  output logic [NUM_BITS-1:0]       q
);

  cellStrobes_t strobes;

  lcell_store_ctrl u_ctrl (
    .gsrN       (gsrN),
    .ceEn       (ceEn),
    .lsrIn      (lsrIn),
    .cfgLsrMode (cfgLsrMode),
    .cfgLsrPrio (cfgLsrPrio),
    .strobes    (strobes)
  );

  lcell_store_dp #(.NUM_BITS(NUM_BITS)) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .lutOut    (lutOut),
    .directIn  (directIn),
    .padHoriz  (padHoriz),
    .padVert   (padVert),
    .cfgLatch  (cfgLatch),
    .cfgSetVal (cfgSetVal),
    .cfgSrcSel (cfgSrcSel),
    .q         (q)
  );

endmodule

// File: rtl/lcell_store_chk.sv
module lcell_store_chk #(
  parameter int NUM_BITS = 4
) (
  input logic                clk,
  input logic                gsrN,
  input logic                ceEn,
  input logic                lsrIn,
  input logic [NUM_BITS-1:0] lutOut,
  input logic [NUM_BITS-1:0] cfgLatch,
  input logic [NUM_BITS-1:0] cfgSetVal,
  input logic [1:0]          cfgLsrMode,
  input logic                cfgLsrPrio,
  input logic [NUM_BITS-1:0] q
);

  logic [NUM_BITS-1:0] ffMask;
  logic                syncMode;
  assign ffMask   = ~cfgLatch;
  assign syncMode = (cfgLsrMode == 2'd0) || (cfgLsrMode == 2'd3);

  // R3
  ff_hold_chk: assert property (@(posedge clk) disable iff (!gsrN)
    (!ceEn && !lsrIn && cfgLsrMode != 2'd1) |=> ((q & ffMask) == ($past(q) & ffMask)));

  // R5
  sync_force_chk: assert property (@(posedge clk) disable iff (!gsrN)
    (syncMode && lsrIn && ceEn) |=> ((q & ffMask) == (cfgSetVal & ffMask)));

  // R6
  prio_force_chk: assert property (@(posedge clk) disable iff (!gsrN)
    (syncMode && lsrIn && !ceEn && cfgLsrPrio) |=> ((q & ffMask) == (cfgSetVal & ffMask)));

  // R7
  async_force_chk: assert property (@(posedge clk) disable iff (!gsrN)
    (cfgLsrMode == 2'd1 && lsrIn) |-> (q == cfgSetVal));

  // R8
  select_lut_chk: assert property (@(posedge clk) disable iff (!gsrN)
    (cfgLsrMode == 2'd2 && ceEn && !lsrIn) |=> ((q & ffMask) == ($past(lutOut) & ffMask)));

endmodule

bind lcell_store_bank lcell_store_chk #(.NUM_BITS(NUM_BITS)) u_chk (
  .clk        (clk),
  .gsrN       (gsrN),
  .ceEn       (ceEn),
  .lsrIn      (lsrIn),
  .lutOut     (lutOut),
  .cfgLatch   (cfgLatch),
  .cfgSetVal  (cfgSetVal),
  .cfgLsrMode (cfgLsrMode),
  .cfgLsrPrio (cfgLsrPrio),
  .q          (q)
);

// File: tb/sim_lcell_store_bank.sv
`timescale 1ns/100ps
module sim_lcell_store_bank;

  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          gsrN;
  logic          ceEn;
  logic          lsrIn;
  logic [NB-1:0] lutOut, directIn, padHoriz, padVert;
  logic [NB-1:0] cfgLatch, cfgSetVal;
  logic [1:0]    cfgLsrMode;
  logic          cfgLsrPrio;
  logic [3*NB-1:0] cfgSrcSel;
  logic [NB-1:0] q;

  int checkCount = 0;
  int failCount  = 0;

  always #2.5 clk = ~clk;

  lcell_store_bank #(.NUM_BITS(NB)) u0 (
    .clk(clk), .gsrN(gsrN), .ceEn(ceEn), .lsrIn(lsrIn),
    .lutOut(lutOut), .directIn(directIn), .padHoriz(padHoriz), .padVert(padVert),
    .cfgLatch(cfgLatch), .cfgSetVal(cfgSetVal), .cfgLsrMode(cfgLsrMode),
    .cfgLsrPrio(cfgLsrPrio), .cfgSrcSel(cfgSrcSel), .q(q)
  );

  task automatic check(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: q=%b expected %b", req, act, exp);
    end
  endtask

  // Configuration changes only under global reset
  task automatic configure(input logic [NB-1:0] lat, input logic [NB-1:0] setv,
                           input logic [1:0] mode, input logic prio, input logic [3*NB-1:0] src);
    @(negedge clk);
    gsrN = 1'b0;
    cfgLatch = lat; cfgSetVal = setv; cfgLsrMode = mode; cfgLsrPrio = prio; cfgSrcSel = src;
    lsrIn = 1'b0; ceEn = 1'b0;
    #1 check("R1 reset value", q, setv);
    @(negedge clk);
    gsrN = 1'b1;
  endtask

  localparam logic [3*NB-1:0] ALL_LUT = {3'd1, 3'd1, 3'd1, 3'd1};

  task automatic t_capture_hold();
    configure(4'b0000, 4'b0000, 2'd0, 1'b0, ALL_LUT);
    lutOut = 4'b0110; ceEn = 1'b1;
    #1 check("R2 no change before edge", q, 4'b0000);
    @(posedge clk); #1 check("R2 capture", q, 4'b0110);
    @(negedge clk); lutOut = 4'b1001; ceEn = 1'b0;
    @(posedge clk); #1 check("R3 hold with enable low", q, 4'b0110);
    @(negedge clk); ceEn = 1'b1;
    @(posedge clk); #1 check("R2 capture second pattern", q, 4'b1001);
  endtask

  task automatic t_sources();
    configure(4'b0000, 4'b1111, 2'd0, 1'b0, {3'd4, 3'd3, 3'd2, 3'd1});
    lutOut = 4'b0001; directIn = 4'b0010; padHoriz = 4'b0100; padVert = 4'b1000; ceEn = 1'b1;
    @(posedge clk); #1 check("R4 one-hot source map", q, 4'b1111);
    @(negedge clk); lutOut = 4'b1110; directIn = 4'b1101; padHoriz = 4'b1011; padVert = 4'b0111;
    @(posedge clk); #1 check("R4 wrong source leak", q, 4'b0000);
    configure(4'b0000, 4'b1111, 2'd0, 1'b0, {3'd7, 3'd6, 3'd5, 3'd0});
    lutOut = 4'b1111; directIn = 4'b1111; padHoriz = 4'b1111; padVert = 4'b1111; ceEn = 1'b1;
    @(posedge clk); #1 check("R4 zero codes", q, 4'b0000);
  endtask

  task automatic t_sync_lsr();
    configure(4'b0000, 4'b0101, 2'd0, 1'b0, ALL_LUT);
    lutOut = 4'b1010; ceEn = 1'b1;
    @(posedge clk); #1 check("R2 preload", q, 4'b1010);
    @(negedge clk); lsrIn = 1'b1;
    #1 check("R5 no force before edge", q, 4'b1010);
    @(posedge clk); #1 check("R5 sync force", q, 4'b0101);
    @(negedge clk); lsrIn = 1'b0;
    @(posedge clk); #1 check("R2 reload", q, 4'b1010);
    @(negedge clk); ceEn = 1'b0; lsrIn = 1'b1;
    @(posedge clk); #1 check("R6 no priority holds", q, 4'b1010);
    configure(4'b0000, 4'b0101, 2'd3, 1'b1, ALL_LUT);
    lutOut = 4'b1010; ceEn = 1'b1;
    @(posedge clk); #1 check("R2 preload prio", q, 4'b1010);
    @(negedge clk); ceEn = 1'b0; lsrIn = 1'b1;
    @(posedge clk); #1 check("R6 priority forces", q, 4'b0101);
    @(negedge clk); lsrIn = 1'b0;
  endtask

  task automatic t_async_lsr();
    configure(4'b0000, 4'b0011, 2'd1, 1'b0, ALL_LUT);
    lutOut = 4'b1100; ceEn = 1'b1;
    @(posedge clk); #1 check("R2 preload async", q, 4'b1100);
    @(negedge clk); #0.5 lsrIn = 1'b1;
    #0.5 check("R7 immediate force", q, 4'b0011);
    @(posedge clk); #1 check("R7 held while asserted", q, 4'b0011);
    @(negedge clk); lsrIn = 1'b0;
    @(posedge clk); #1 check("R2 reload after async", q, 4'b1100);
    @(negedge clk); #0.5 gsrN = 1'b0;
    #0.5 check("R1 global mid-run", q, 4'b0011);
    @(negedge clk); gsrN = 1'b1;
  endtask

  task automatic t_select();
    configure(4'b0000, 4'b1111, 2'd2, 1'b1, {3'd0, 3'd0, 3'd0, 3'd0});
    lutOut = 4'b0110; directIn = 4'b1001; ceEn = 1'b1; lsrIn = 1'b0;
    @(posedge clk); #1 check("R8 select lut", q, 4'b0110);
    @(negedge clk); lsrIn = 1'b1;
    #1 check("R8 no async force", q, 4'b0110);
    @(posedge clk); #1 check("R8 select direct", q, 4'b1001);
    @(negedge clk); lsrIn = 1'b0;
  endtask

  task automatic t_latch();
    configure(4'b1111, 4'b0000, 2'd0, 1'b0, ALL_LUT);
    lutOut = 4'b1011; ceEn = 1'b0;
    #1 check("R9 hold while gate low", q, 4'b0000);
    @(posedge clk); #1 check("R9 transparent, enable ignored", q, 4'b1011);
    lutOut = 4'b0100;
    #0.5 check("R9 follows while high", q, 4'b0100);
    @(negedge clk); #0.5 lutOut = 4'b1111;
    #0.5 check("R9 holds after fall", q, 4'b0100);
    configure(4'b1111, 4'b0110, 2'd0, 1'b0, ALL_LUT);
    lutOut = 4'b1001; ceEn = 1'b0;
    @(posedge clk); #1 check("R9 transparent again", q, 4'b1001);
    lsrIn = 1'b1;
    #0.5 check("R10 latch sync force", q, 4'b0110);
    @(negedge clk); lsrIn = 1'b0;
  endtask

  initial begin
    gsrN = 1'b0; ceEn = 1'b0; lsrIn = 1'b0;
    lutOut = '0; directIn = '0; padHoriz = '0; padVert = '0;
    cfgLatch = '0; cfgSetVal = '0; cfgLsrMode = 2'd0; cfgLsrPrio = 1'b0; cfgSrcSel = ALL_LUT;
    repeat (2) @(negedge clk);
    t_capture_hold();
    t_sources();
    t_sync_lsr();
    t_async_lsr();
    t_select();
    t_latch();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #50000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule